// File: doc/BRIEF.md
# SMBus Transaction Sequencer

This block runs one complete SMBus transaction on top of a byte-level I2C master. It does not drive the bus wires. It tells the byte engine when to generate START and STOP, which byte to shift out, and whether the next received byte is to be answered with a NACK. The engine reports back with per-byte events: byte done or data ready, negative acknowledge, bus error, and a level that says whether it still owns the bus as master.

A host loads outgoing payload into a small byte buffer. It then presents a 7-bit target address, a direction flag, a command code, a transaction kind and (for block transfers) a length, and pulses `go`. The sequencer emits the address and command phases. For reads it inserts a repeated START and then streams the payload. It finishes with a one-cycle `done` pulse and a result code. Bytes that are read land in the same buffer, starting at index 0, and the host reads them back through a separate read port.

A hard failure also raises `need_reset`, which asks the surrounding logic to reinitialise the byte engine. Hard failures are a bus error, loss of mastership, or a silence that outlasts a cycle-counted timeout.

Top module: `smbus_seq`

## Requirements
- R1: Every address byte the sequencer sends is the 7-bit address shifted left by one. Bit 0 holds the direction: 1 = read, 0 = write.
- R2: Kinds are encoded on `kind` as 0 = quick, 1 = single byte, 2 = byte-data, 3 = word-data, 4 = block. Quick and single-byte transactions send the address with its real direction bit as the first byte after START. All other kinds first send the address with bit 0 forced to 0, then the command code.
- R3: For a read of kind 2, 3 or 4, the ready event after the command byte pulses `be_start` for a repeated START. In the same cycle it writes the address with bit 0 set.
- R4: `be_nack_arm` is set when the read address is sent if the read length is 1, and cleared otherwise. On each received byte it is set when exactly two bytes remained before that byte, and cleared otherwise.
- R5: Received bytes are stored at buffer index 0, 1, 2, … in arrival order, so a word arrives low byte first. On the last received byte, `be_stop` and `done` pulse with result 0 (success). A write sends buffer bytes from index 0 upward. Once all of them are acknowledged, the next ready event pulses `be_stop` and `done` with result 0.
- R6: A negative acknowledge while busy pulses `be_stop` and `be_clr` together with `done`, gives result 1 (no device), returns to idle and leaves `need_reset` low.
- R7: A bus error, or any event seen while `st_master` is low, ends the transaction with result 2 (I/O error). It raises `need_reset` and sends no STOP. `need_reset` stays high until the next accepted `go`.
- R8: If no event arrives for `TIMEOUT_CYC` clock cycles while busy, the transaction ends with result 2 and `need_reset` set. `busy` is still high one cycle before that point.
- R9: The following requests pulse `done` one cycle after `go` with result 3 (invalid) and issue no START: a quick read, or a block request whose length is 0 or above `MAX_BLK` (default 32).
- R10: `busy` rises on the cycle after an accepted `go`, together with a `be_start` pulse, and stays high until the transaction ends. Engine events while idle cause no output activity.
- R11: A single-byte write (kind 1, write) sends the command code as its one data byte after the address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| go | input | 1 | Start a transaction (ignored while busy) |
| addr | input | 7 | Target address |
| rd_nwr | input | 1 | 1 = read, 0 = write |
| code | input | 8 | Command code |
| kind | input | 3 | Transaction kind (see R2) |
| len | input | LENW | Block length (kind 4 only) |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 2 | 0 ok, 1 no device, 2 I/O error, 3 invalid |
| need_reset | output | 1 | Byte engine must be reinitialised |
| buf_we | input | 1 | Host buffer write (ignored while busy) |
| buf_widx | input | IDXW | Host buffer write index |
| buf_wdata | input | 8 | Host buffer write data |
| buf_ridx | input | IDXW | Host buffer read index |
| buf_rdata | output | 8 | Host buffer read data |
| ev_ready | input | 1 | Engine: byte done / data ready |
| ev_nack | input | 1 | Engine: negative acknowledge |
| ev_berr | input | 1 | Engine: bus error |
| st_master | input | 1 | Engine: currently bus master |
| rx_byte | input | 8 | Engine: received byte |
| be_start | output | 1 | Request (repeated) START |
| be_stop | output | 1 | Request STOP |
| be_wr | output | 1 | Transmit `be_wdata` |
| be_wdata | output | 8 | Byte to transmit |
| be_nack_arm | output | 1 | Answer the next received byte with NACK |
| be_clr | output | 1 | Clear engine NACK and stall flags |

## Verification
A wrong state shows at the ports one cycle after the next engine event. It appears as a byte on `be_wdata` with the wrong value or direction bit, a missing or extra `be_start` or `be_stop`, or a `be_nack_arm` level that disagrees with the remaining count. A wrong remaining count goes unseen until the end of the transfer, where it shows as a STOP one byte early or late, or as received bytes at the wrong buffer index. Error paths show in the same cycle after the event, through `result`, `need_reset` and the absence of STOP on hard errors.

// File: rtl/smbus_seq_pkg.sv
package smbus_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_ADDR   = 3'd1,
    ST_CMD    = 3'd2,
    ST_RSTART = 3'd3,
    ST_QUICK  = 3'd4,
    ST_READ   = 3'd5,
    ST_WRITE  = 3'd6
  } seq_state_e;

  localparam logic [2:0] KIND_QUICK = 3'd0;
  localparam logic [2:0] KIND_BYTE  = 3'd1;
  localparam logic [2:0] KIND_BDATA = 3'd2;
  localparam logic [2:0] KIND_WORD  = 3'd3;
  localparam logic [2:0] KIND_BLOCK = 3'd4;

  localparam logic [1:0] RES_OK    = 2'd0;
  localparam logic [1:0] RES_NODEV = 2'd1;
  localparam logic [1:0] RES_IOERR = 2'd2;
  localparam logic [1:0] RES_INVAL = 2'd3;

endpackage

// File: rtl/smbus_seq_req.sv
module smbus_seq_req
  import smbus_seq_pkg::*;
#(
  parameter int MAX_BLK = 32,
  parameter int LENW    = 6
) (
  input  logic [2:0]      kind,
  input  logic            rd,
  input  logic [LENW-1:0] len_in,
  output logic            ok,
  output logic [LENW-1:0] len_out,
  output logic            quick_entry
);

  // Translate a request into a payload length and entry point
  always_comb begin
    ok          = 1'b1;
    len_out     = '0;
    quick_entry = 1'b0;
    case (kind)
      KIND_QUICK: begin
        quick_entry = 1'b1;
        ok          = !rd;          // nothing to read back
      end
      KIND_BYTE: begin
        quick_entry = 1'b1;
        len_out     = LENW'(1);
      end
      KIND_BDATA: len_out = LENW'(1);
      KIND_WORD:  len_out = LENW'(2);
      KIND_BLOCK: begin
        len_out = len_in;
        ok      = (len_in != '0) && (len_in <= LENW'(MAX_BLK));
      end
      default: ok = 1'b0;
    endcase
  end

endmodule

// File: rtl/smbus_seq_buf.sv
module smbus_seq_buf #(
  parameter int DEPTH = 32,
  parameter int IDXW  = 5
) (
  input  logic            clk,
  input  logic            wr_en,
  input  logic [IDXW-1:0] wr_idx,
  input  logic [7:0]      wr_data,
  input  logic [IDXW-1:0] ra_idx,
  output logic [7:0]      ra_data,
  input  logic [IDXW-1:0] rb_idx,
  output logic [7:0]      rb_data
);

  logic [7:0] mem_q [DEPTH];

  // Payload storage: no reset, written with an explicit enable
  always_ff @(posedge clk) begin
    if (wr_en) mem_q[wr_idx] <= wr_data;
  end

  assign ra_data = mem_q[ra_idx];
  assign rb_data = mem_q[rb_idx];

endmodule

// File: rtl/smbus_seq_tmo.sv
module smbus_seq_tmo #(
  parameter int TIMEOUT_CYC = 20_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic run,
  output logic expire
);

  localparam int CW = $clog2(TIMEOUT_CYC + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt_q <= '0;
    else if (clear) cnt_q <= '0;
    else if (run)   cnt_q <= cnt_q + CW'(1);
  end

  assign expire = run && !clear && (cnt_q == CW'(TIMEOUT_CYC - 1));

endmodule

// File: rtl/smbus_seq_fsm.sv
module smbus_seq_fsm
  import smbus_seq_pkg::*;
#(
  parameter int LENW = 6,
  parameter int IDXW = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            go,
  input  logic [6:0]      addr7,
  input  logic            rd,
  input  logic [7:0]      code,
  input  logic [2:0]      kind,
  input  logic            req_ok,
  input  logic [LENW-1:0] req_len,
  input  logic            req_quick,
  input  logic            ev_ready,
  input  logic            ev_nack,
  input  logic            ev_berr,
  input  logic            st_master,
  input  logic [7:0]      rx_byte,
  input  logic            tmo_expire,
  input  logic [7:0]      buf_q,
  output logic [IDXW-1:0] buf_idx,
  output logic            buf_we,
  output logic [7:0]      buf_wd,
  output logic            tmo_clear,
  output logic            busy,
  output logic            be_start,
  output logic            be_stop,
  output logic            be_wr,
  output logic [7:0]      be_wdata,
  output logic            be_nack_arm,
  output logic            be_clr,
  output logic            done,
  output logic [1:0]      result,
  output logic            need_reset
);

  seq_state_e      state_q, state_d;
  logic [7:0]      addr_q, addr_d;
  logic [7:0]      code_q, code_d;
  logic [LENW-1:0] rem_q, rem_d;
  logic [IDXW-1:0] idx_q, idx_d;
  logic            cdat_q, cdat_d;     // single-byte write: payload is the code
  logic            start_q, start_d;
  logic            stop_q, stop_d;
  logic            wr_q, wr_d;
  logic [7:0]      wdata_q, wdata_d;
  logic            narm_q, narm_d;
  logic            clr_q, clr_d;
  logic            done_q, done_d;
  logic [1:0]      res_q, res_d;
  logic            need_q, need_d;

  logic ev_any;
  logic accept;

  assign ev_any    = ev_ready | ev_nack | ev_berr;
  assign accept    = (state_q == ST_IDLE) && go && req_ok;
  assign tmo_clear = ev_any | accept;
  assign busy      = (state_q != ST_IDLE);
  assign buf_idx   = idx_q;
  assign buf_wd    = rx_byte;

  // Next-state and action decode
  always_comb begin
    state_d = state_q;
    addr_d  = addr_q;
    code_d  = code_q;
    rem_d   = rem_q;
    idx_d   = idx_q;
    cdat_d  = cdat_q;
    start_d = 1'b0;
    stop_d  = 1'b0;
    wr_d    = 1'b0;
    wdata_d = wdata_q;
    narm_d  = narm_q;
    clr_d   = 1'b0;
    done_d  = 1'b0;
    res_d   = res_q;
    need_d  = need_q;
    buf_we  = 1'b0;

    if (state_q == ST_IDLE) begin
      if (go) begin
        if (!req_ok) begin
          done_d = 1'b1;
          res_d  = RES_INVAL;
        end else begin
          addr_d  = {addr7, rd};
          code_d  = code;
          rem_d   = req_len;
          idx_d   = '0;
          cdat_d  = (kind == KIND_BYTE) && !rd;
          need_d  = 1'b0;
          narm_d  = 1'b0;
          start_d = 1'b1;
          state_d = req_quick ? ST_QUICK : ST_ADDR;
        end
      end
    end else if (ev_any) begin
      if (ev_berr || !st_master) begin
        state_d = ST_IDLE;
        done_d  = 1'b1;
        res_d   = RES_IOERR;
        need_d  = 1'b1;
      end else if (ev_nack) begin
        state_d = ST_IDLE;
        stop_d  = 1'b1;
        clr_d   = 1'b1;
        done_d  = 1'b1;
        res_d   = RES_NODEV;
      end else begin
        case (state_q)
          ST_ADDR: begin
            wr_d    = 1'b1;
            wdata_d = {addr_q[7:1], 1'b0};
            state_d = ST_CMD;
          end
          ST_CMD: begin
            wr_d    = 1'b1;
            wdata_d = code_q;
            state_d = addr_q[0] ? ST_RSTART : ST_WRITE;
          end
          ST_RSTART, ST_QUICK: begin
            start_d = (state_q == ST_RSTART);
            wr_d    = 1'b1;
            wdata_d = addr_q;
            if (addr_q[0]) begin
              narm_d  = (rem_q == LENW'(1));
              state_d = ST_READ;
            end else begin
              state_d = ST_WRITE;
            end
          end
          ST_READ: begin
            narm_d = (rem_q == LENW'(2));
            buf_we = 1'b1;
            idx_d  = idx_q + IDXW'(1);
            rem_d  = rem_q - LENW'(1);
            if (rem_q == LENW'(1)) begin
              stop_d  = 1'b1;
              done_d  = 1'b1;
              res_d   = RES_OK;
              state_d = ST_IDLE;
            end
          end
          ST_WRITE: begin
            if (rem_q == '0) begin
              stop_d  = 1'b1;
              done_d  = 1'b1;
              res_d   = RES_OK;
              state_d = ST_IDLE;
            end else begin
              wr_d    = 1'b1;
              wdata_d = cdat_q ? code_q : buf_q;
              idx_d   = idx_q + IDXW'(1);
              rem_d   = rem_q - LENW'(1);
            end
          end
          default: state_d = ST_IDLE;
        endcase
      end
    end else if (tmo_expire) begin
      state_d = ST_IDLE;
      done_d  = 1'b1;
      res_d   = RES_IOERR;
      need_d  = 1'b1;
    end
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      code_q  <= '0;
      rem_q   <= '0;
      idx_q   <= '0;
      cdat_q  <= 1'b0;
      start_q <= 1'b0;
      stop_q  <= 1'b0;
      wr_q    <= 1'b0;
      wdata_q <= '0;
      narm_q  <= 1'b0;
      clr_q   <= 1'b0;
      done_q  <= 1'b0;
      res_q   <= RES_OK;
      need_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        addr_q <= addr_d;
        code_q <= code_d;
        cdat_q <= cdat_d;
      end
      rem_q   <= rem_d;
      idx_q   <= idx_d;
      start_q <= start_d;
      stop_q  <= stop_d;
      wr_q    <= wr_d;
      if (wr_d) wdata_q <= wdata_d;
      narm_q  <= narm_d;
      clr_q   <= clr_d;
      done_q  <= done_d;
      res_q   <= res_d;
      need_q  <= need_d;
    end
  end

  assign be_start    = start_q;
  assign be_stop     = stop_q;
  assign be_wr       = wr_q;
  assign be_wdata    = wdata_q;
  assign be_nack_arm = narm_q;
  assign be_clr      = clr_q;
  assign done        = done_q;
  assign result      = res_q;
  assign need_reset  = need_q;

endmodule

// File: rtl/smbus_seq.sv
module smbus_seq #(
  parameter int MAX_BLK     = 32,
  parameter int TIMEOUT_CYC = 20_000_000,
  parameter int LENW        = $clog2(MAX_BLK + 1),
  parameter int IDXW        = $clog2(MAX_BLK)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            go,
  input  logic [6:0]      addr,
  input  logic            rd_nwr,
  input  logic [7:0]      code,
  input  logic [2:0]      kind,
  input  logic [LENW-1:0] len,
  output logic            busy,
  output logic            done,
  output logic [1:0]      result,
  output logic            need_reset,
  input  logic            buf_we,
  input  logic [IDXW-1:0] buf_widx,
  input  logic [7:0]      buf_wdata,
  input  logic [IDXW-1:0] buf_ridx,
  output logic [7:0]      buf_rdata,
  input  logic            ev_ready,
  input  logic            ev_nack,
  input  logic            ev_berr,
  input  logic            st_master,
  input  logic [7:0]      rx_byte,
  output logic            be_start,
  output logic            be_stop,
  output logic            be_wr,
  output logic [7:0]      be_wdata,
  output logic            be_nack_arm,
  output logic            be_clr
);

  // Reset: asserted asynchronously, released on the clock
  logic [1:0] rsync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_int_n = rsync_q[1];

  logic            req_ok;
  logic [LENW-1:0] req_len;
  logic            req_quick;
  logic            tmo_clear;
  logic            tmo_expire;
  logic [IDXW-1:0] seq_idx;
  logic            seq_we;
  logic [7:0]      seq_wd;
  logic [7:0]      seq_q;
  logic            mem_we;
  logic [IDXW-1:0] mem_widx;
  logic [7:0]      mem_wd;

  smbus_seq_req #(.MAX_BLK(MAX_BLK), .LENW(LENW)) u_req (
    .kind        (kind),
    .rd          (rd_nwr),
    .len_in      (len),
    .ok          (req_ok),
    .len_out     (req_len),
    .quick_entry (req_quick)
  );

  // Sequencer stores take the buffer; host writes only while idle
  assign mem_we   = seq_we | (buf_we & ~busy);
  assign mem_widx = seq_we ? seq_idx : buf_widx;
  assign mem_wd   = seq_we ? seq_wd  : buf_wdata;

  smbus_seq_buf #(.DEPTH(MAX_BLK), .IDXW(IDXW)) u_buf (
    .clk     (clk),
    .wr_en   (mem_we),
    .wr_idx  (mem_widx),
    .wr_data (mem_wd),
    .ra_idx  (seq_idx),
    .ra_data (seq_q),
    .rb_idx  (buf_ridx),
    .rb_data (buf_rdata)
  );

  smbus_seq_tmo #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_tmo (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .clear  (tmo_clear),
    .run    (busy),
    .expire (tmo_expire)
  );

  smbus_seq_fsm #(.LENW(LENW), .IDXW(IDXW)) u_fsm (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .go          (go),
    .addr7       (addr),
    .rd          (rd_nwr),
    .code        (code),
    .kind        (kind),
    .req_ok      (req_ok),
    .req_len     (req_len),
    .req_quick   (req_quick),
    .ev_ready    (ev_ready),
    .ev_nack     (ev_nack),
    .ev_berr     (ev_berr),
    .st_master   (st_master),
    .rx_byte     (rx_byte),
    .tmo_expire  (tmo_expire),
    .buf_q       (seq_q),
    .buf_idx     (seq_idx),
    .buf_we      (seq_we),
    .buf_wd      (seq_wd),
    .tmo_clear   (tmo_clear),
    .busy        (busy),
    .be_start    (be_start),
    .be_stop     (be_stop),
    .be_wr       (be_wr),
    .be_wdata    (be_wdata),
    .be_nack_arm (be_nack_arm),
    .be_clr      (be_clr),
    .done        (done),
    .result      (result),
    .need_reset  (need_reset)
  );

endmodule

// File: rtl/smbus_seq_sva.sv
module smbus_seq_sva (
  input logic       clk,
  input logic       rst_n,
  input logic       go,
  input logic       rd_nwr,
  input logic [2:0] kind,
  input logic       busy,
  input logic       done,
  input logic [1:0] result,
  input logic       need_reset,
  input logic       ev_ready,
  input logic       ev_nack,
  input logic       ev_berr,
  input logic       st_master,
  input logic       be_start,
  input logic       be_stop,
  input logic       be_wr,
  input logic       be_clr
);

  // R6: NACK ends the transfer with STOP, flag clear and no-device
  a_r6_nack_stop: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && ev_nack && !ev_berr && st_master) |=>
      (be_stop && be_clr && done && result == 2'd1 && !busy));

  // R7: hard errors give an I/O error and a reset request, no STOP
  a_r7_hard_error: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && (ev_berr || ((ev_ready || ev_nack) && !st_master))) |=>
      (done && result == 2'd2 && need_reset && !busy && !be_stop));

  // R9: a quick read is refused without a START
  a_r9_quick_read_reject: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && go && kind == 3'd0 && rd_nwr) |=>
      (done && result == 2'd3 && !busy && !be_start));

  // R10: busy rises only with a START following go
  a_r10_busy_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (be_start && $past(go)));

  // R10: an idle sequencer makes no requests
  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !go) |=> (!be_wr && !be_start && !be_stop && !done));

  // R5: completion is a single-cycle pulse
  a_r5_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !go) |=> !done);

endmodule

bind smbus_seq smbus_seq_sva u_sva (
  .clk        (clk),
  .rst_n      (rst_n),
  .go         (go),
  .rd_nwr     (rd_nwr),
  .kind       (kind),
  .busy       (busy),
  .done       (done),
  .result     (result),
  .need_reset (need_reset),
  .ev_ready   (ev_ready),
  .ev_nack    (ev_nack),
  .ev_berr    (ev_berr),
  .st_master  (st_master),
  .be_start   (be_start),
  .be_stop    (be_stop),
  .be_wr      (be_wr),
  .be_clr     (be_clr)
);

// File: tb/smbus_seq_test.sv
module smbus_seq_test;

  localparam int CLK_PERIOD = 10;
  localparam int TMO        = 40;
  localparam int LENW       = 6;
  localparam int IDXW       = 5;
  localparam logic [2:0] KQ = 3'd0, KB = 3'd1, KBD = 3'd2, KW = 3'd3, KBL = 3'd4;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            go;
  logic [6:0]      addr;
  logic            rd_nwr;
  logic [7:0]      code;
  logic [2:0]      kind;
  logic [LENW-1:0] len;
  logic            busy, done, need_reset;
  logic [1:0]      result;
  logic            buf_we;
  logic [IDXW-1:0] buf_widx, buf_ridx;
  logic [7:0]      buf_wdata, buf_rdata;
  logic            ev_ready, ev_nack, ev_berr, st_master;
  logic [7:0]      rx_byte;
  logic            be_start, be_stop, be_wr, be_nack_arm, be_clr;
  logic [7:0]      be_wdata;

  int checks = 0;
  int errors = 0;

  smbus_seq #(.MAX_BLK(32), .TIMEOUT_CYC(TMO)) uut (
    .clk(clk), .rst_n(rst_n), .go(go), .addr(addr), .rd_nwr(rd_nwr),
    .code(code), .kind(kind), .len(len), .busy(busy), .done(done),
    .result(result), .need_reset(need_reset), .buf_we(buf_we),
    .buf_widx(buf_widx), .buf_wdata(buf_wdata), .buf_ridx(buf_ridx),
    .buf_rdata(buf_rdata), .ev_ready(ev_ready), .ev_nack(ev_nack),
    .ev_berr(ev_berr), .st_master(st_master), .rx_byte(rx_byte),
    .be_start(be_start), .be_stop(be_stop), .be_wr(be_wr),
    .be_wdata(be_wdata), .be_nack_arm(be_nack_arm), .be_clr(be_clr)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // All tasks start and end at a falling edge
  task automatic host_wr(input int idx, input logic [7:0] d);
    buf_we = 1'b1; buf_widx = IDXW'(idx); buf_wdata = d;
    @(negedge clk);
    buf_we = 1'b0;
  endtask

  task automatic host_rd(input int idx, output logic [7:0] d);
    buf_ridx = IDXW'(idx);
    #1 d = buf_rdata;
  endtask

  task automatic start_tx(input logic [2:0] k, input logic [6:0] a, input logic r,
                          input logic [7:0] c, input int n);
    kind = k; addr = a; rd_nwr = r; code = c; len = LENW'(n); go = 1'b1;
    @(negedge clk);
    go = 1'b0;
  endtask

  task automatic evt(input logic rdy, input logic nk, input logic be,
                     input logic ms, input logic [7:0] rx);
    ev_ready = rdy; ev_nack = nk; ev_berr = be; st_master = ms; rx_byte = rx;
    @(negedge clk);
    ev_ready = 1'b0; ev_nack = 1'b0; ev_berr = 1'b0; st_master = 1'b1;
  endtask

  task automatic look(input string tag, input logic s, input logic p,
                      input logic w, input logic [7:0] d);
    chk({tag, " start"}, be_start, s);
    chk({tag, " stop"}, be_stop, p);
    chk({tag, " wr"}, be_wr, w);
    if (w) chk({tag, " wdata"}, be_wdata, d);
  endtask

  task automatic fin(input string tag, input logic [1:0] res);
    chk({tag, " done"}, done, 1'b1);
    chk({tag, " result"}, result, res);
    chk({tag, " busy low"}, busy, 1'b0);
  endtask

  task automatic t_reset;
    chk("R10 reset busy", busy, 0);
    chk("R10 reset done", done, 0);
    chk("R7 reset need_reset", need_reset, 0);
    look("R10 reset", 0, 0, 0, 8'h00);
    chk("R4 reset nack_arm", be_nack_arm, 0);
  endtask

  task automatic t_idle_ignore;
    evt(1, 0, 0, 1, 8'h00);
    look("R10 idle ready", 0, 0, 0, 8'h00);
    chk("R10 idle no done", done, 0);
    evt(0, 1, 0, 1, 8'h00);
    chk("R10 idle nack no stop", be_stop, 0);
    chk("R10 idle nack no clr", be_clr, 0);
  endtask

  task automatic t_bdata_write;
    host_wr(0, 8'hA5);
    start_tx(KBD, 7'h50, 0, 8'h10, 0);
    chk("R10 busy after go", busy, 1);
    look("R10 go start", 1, 0, 0, 8'h00);
    evt(1, 0, 0, 1, 8'h00); look("R2 bdata addr", 0, 0, 1, 8'hA0);
    evt(1, 0, 0, 1, 8'h00); look("R2 bdata cmd", 0, 0, 1, 8'h10);
    evt(1, 0, 0, 1, 8'h00); look("R5 bdata payload", 0, 0, 1, 8'hA5);
    chk("R10 busy mid", busy, 1);
    evt(1, 0, 0, 1, 8'h00); look("R5 bdata end", 0, 1, 0, 8'h00);
    fin("R5 bdata", 2'd0);
  endtask

  task automatic t_word_read;
    logic [7:0] d;
    start_tx(KW, 7'h48, 1, 8'h02, 0);
    evt(1, 0, 0, 1, 8'h00); look("R2 word addr forced write", 0, 0, 1, 8'h90);
    evt(1, 0, 0, 1, 8'h00); look("R2 word cmd", 0, 0, 1, 8'h02);
    evt(1, 0, 0, 1, 8'h00); look("R3 word restart", 1, 0, 1, 8'h91);
    chk("R4 word arm at addr", be_nack_arm, 0);
    evt(1, 0, 0, 1, 8'h34);
    chk("R4 word arm two left", be_nack_arm, 1);
    chk("R5 word no early stop", be_stop, 0);
    evt(1, 0, 0, 1, 8'h12);
    chk("R4 word arm last", be_nack_arm, 0);
    chk("R5 word stop", be_stop, 1);
    fin("R5 word", 2'd0);
    host_rd(0, d); chk("R5 word low first", d, 8'h34);
    host_rd(1, d); chk("R5 word high second", d, 8'h12);
  endtask

  task automatic t_quick_write;
    start_tx(KQ, 7'h22, 0, 8'hFF, 0);
    evt(1, 0, 0, 1, 8'h00); look("R1 quick addr", 0, 0, 1, 8'h44);
    evt(1, 0, 0, 1, 8'h00); look("R5 quick end", 0, 1, 0, 8'h00);
    fin("R5 quick", 2'd0);
  endtask

  task automatic t_byte_write;
    start_tx(KB, 7'h30, 0, 8'h77, 0);
    evt(1, 0, 0, 1, 8'h00); look("R2 byte skips cmd", 0, 0, 1, 8'h60);
    evt(1, 0, 0, 1, 8'h00); look("R11 byte sends code", 0, 0, 1, 8'h77);
    evt(1, 0, 0, 1, 8'h00); look("R11 byte end", 0, 1, 0, 8'h00);
    fin("R11 byte", 2'd0);
  endtask

  task automatic t_byte_read;
    logic [7:0] d;
    start_tx(KB, 7'h30, 1, 8'h00, 0);
    evt(1, 0, 0, 1, 8'h00); look("R1 byte read addr", 0, 0, 1, 8'h61);
    chk("R4 len1 arm", be_nack_arm, 1);
    evt(1, 0, 0, 1, 8'h5A);
    chk("R5 byte read stop", be_stop, 1);
    fin("R5 byte read", 2'd0);
    host_rd(0, d); chk("R5 byte read data", d, 8'h5A);
  endtask

  task automatic t_block_write;
    host_wr(0, 8'h01); host_wr(1, 8'h02); host_wr(2, 8'h03);
    start_tx(KBL, 7'h11, 0, 8'h40, 3);
    evt(1, 0, 0, 1, 8'h00); look("R2 blk addr", 0, 0, 1, 8'h22);
    evt(1, 0, 0, 1, 8'h00); look("R2 blk cmd", 0, 0, 1, 8'h40);
    evt(1, 0, 0, 1, 8'h00); look("R5 blk b0", 0, 0, 1, 8'h01);
    evt(1, 0, 0, 1, 8'h00); look("R5 blk b1", 0, 0, 1, 8'h02);
    evt(1, 0, 0, 1, 8'h00); look("R5 blk b2", 0, 0, 1, 8'h03);
    evt(1, 0, 0, 1, 8'h00); look("R5 blk end", 0, 1, 0, 8'h00);
    fin("R5 blk write", 2'd0);
  endtask

  task automatic t_block_read;
    logic [7:0] d;
    start_tx(KBL, 7'h11, 1, 8'h20, 3);
    evt(1, 0, 0, 1, 8'h00); look("R2 blkrd addr", 0, 0, 1, 8'h22);
    evt(1, 0, 0, 1, 8'h00); look("R2 blkrd cmd", 0, 0, 1, 8'h20);
    evt(1, 0, 0, 1, 8'h00); look("R3 blkrd restart", 1, 0, 1, 8'h23);
    chk("R4 blkrd arm len3", be_nack_arm, 0);
    evt(1, 0, 0, 1, 8'hA1); chk("R4 blkrd arm 3 left", be_nack_arm, 0);
    evt(1, 0, 0, 1, 8'hA2); chk("R4 blkrd arm 2 left", be_nack_arm, 1);
    chk("R5 blkrd no stop yet", be_stop, 0);
    evt(1, 0, 0, 1, 8'hA3); chk("R5 blkrd stop", be_stop, 1);
    fin("R5 blkrd", 2'd0);
    for (int i = 0; i < 3; i++) begin
      host_rd(i, d);
      chk("R5 blkrd order", d, 8'hA1 + 8'(i));
    end
  endtask

  task automatic t_nack;
    start_tx(KBD, 7'h50, 0, 8'h10, 0);
    evt(1, 0, 0, 1, 8'h00);
    evt(0, 1, 0, 1, 8'h00);
    chk("R6 nack stop", be_stop, 1);
    chk("R6 nack clr", be_clr, 1);
    fin("R6 nack", 2'd1);
    chk("R6 nack no reset req", need_reset, 0);
  endtask

  task automatic t_berr;
    start_tx(KW, 7'h48, 1, 8'h02, 0);
    evt(1, 0, 0, 1, 8'h00);
    evt(0, 0, 1, 1, 8'h00);
    chk("R7 berr no stop", be_stop, 0);
    fin("R7 berr", 2'd2);
    chk("R7 berr need_reset", need_reset, 1);
    @(negedge clk);
    chk("R7 need_reset held", need_reset, 1);
    start_tx(KQ, 7'h22, 0, 8'h00, 0);
    chk("R7 need_reset cleared by go", need_reset, 0);
    evt(1, 0, 0, 0, 8'h00);
    fin("R7 master lost", 2'd2);
    chk("R7 master lost need_reset", need_reset, 1);
  endtask

  task automatic t_timeout;
    start_tx(KBD, 7'h50, 0, 8'h10, 0);
    repeat (TMO - 1) @(negedge clk);
    chk("R8 busy before timeout", busy, 1);
    repeat (2) @(negedge clk);
    chk("R8 timeout busy", busy, 0);
    chk("R8 timeout result", result, 2'd2);
    chk("R8 timeout need_reset", need_reset, 1);
  endtask

  task automatic t_reject;
    start_tx(KQ, 7'h22, 1, 8'h00, 0);
    chk("R9 quick read no start", be_start, 0);
    fin("R9 quick read", 2'd3);
    start_tx(KBL, 7'h22, 0, 8'h00, 0);
    chk("R9 blk0 no start", be_start, 0);
    fin("R9 blk0", 2'd3);
    start_tx(KBL, 7'h22, 1, 8'h00, 33);
    chk("R9 blk33 no start", be_start, 0);
    fin("R9 blk33", 2'd3);
    start_tx(KBL, 7'h22, 0, 8'h00, 32);
    chk("R9 blk32 accepted", be_start, 1);
    evt(0, 1, 0, 1, 8'h00);
    fin("R9 blk32 nack cleanup", 2'd1);
  endtask

  initial begin
    repeat (100_000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; go = 1'b0; addr = '0; rd_nwr = 1'b0; code = '0; kind = '0;
    len = '0; buf_we = 1'b0; buf_widx = '0; buf_wdata = '0; buf_ridx = '0;
    ev_ready = 1'b0; ev_nack = 1'b0; ev_berr = 1'b0; st_master = 1'b1;
    rx_byte = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset;
    t_idle_ignore;
    t_bdata_write;
    t_word_read;
    t_quick_write;
    t_byte_write;
    t_byte_read;
    t_block_write;
    t_block_read;
    t_nack;
    t_berr;
    t_timeout;
    t_reject;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule